// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns parallel video into the bit streams for a low-voltage differential panel link. One pixel arrives per pixel period: three 8-bit color components plus horizontal sync, vertical sync and a data-valid flag. The block spreads each pixel over up to four data lanes, with seven bit slots per lane. A companion clock lane carries a fixed seven-slot waveform. The fast bit clock is supplied as the input `fast_en`, a clock enable that pulses seven times per pixel. Each pulse moves every lane on by one slot.

A static two-bit `map_mode` input picks one of three color-to-slot layouts. The first is a three-lane 18-bit layout, in which the fourth lane stays low. The other two are four-lane 24-bit layouts: one sends the most significant bits of each color first, the other keeps the 18-bit layout for the low bits. A `mirror` input sends the data lanes in reverse slot order. The pixel, the mode and the mirror setting are all sampled together at the start of each pixel, so a pixel is never split between two settings.

Top module: `lvds_serializer`

## Requirements
- R1: Each `fast_en` pulse emits one slot on every lane. Slots run 0,1,...,6 and then wrap to 0, slot 0 is the first slot after reset, and a new pixel starts at every slot 0.
- R2: For slots 0 to 6, `lane_clk` carries 1,1,0,0,0,1,1.
- R3: With `map_mode`=2'b00 (18-bit layout), only bits [5:0] of each color are sent. In slot order 0..6 the lanes carry: lane 0 = g0,r5,r4,r3,r2,r1,r0; lane 1 = b1,b0,g5,g4,g3,g2,g1; lane 2 = de,vsync,hsync,b5,b4,b3,b2.
- R4: `map_mode`=2'b11 behaves exactly like 2'b00.
- R5: With `map_mode`=2'b01, lanes 0 to 2 use the R3 slot pattern applied to bits [7:2] of each color (color bit k+2 in place of bit k). Lane 3 carries 0,b1,b0,g1,g0,r1,r0.
- R6: With `map_mode`=2'b10, lanes 0 to 2 are exactly as in R3, using bits [5:0]. Lane 3 carries 0,b7,b6,g7,g6,r7,r6.
- R7: Data-valid is sent in lane 2 slot 0, vertical sync in lane 2 slot 1 and horizontal sync in lane 2 slot 2. Lane 3 slot 0 is always 0.
- R8: With `mirror` sampled as 1, every data lane sends its slots in order 6 down to 0.
- R9: `mirror` never changes the clock lane waveform.
- R10: Colors, sync bits, `map_mode` and `mirror` are sampled only on the `fast_en` pulse that emits slot 0. Changes at any other time take effect at the next pixel.
- R11: While the 18-bit layout (2'b00 or 2'b11) is in use, `lane_data[3]` stays 0.
- R12: While `rst_n` is low at a clock edge, all data lanes and `lane_clk` go to 0 and the slot count restarts at slot 0.
- R13: In a clock cycle without `fast_en`, `lane_data` and `lane_clk` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_en | input | 1 | Slot advance enable, seven per pixel |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data valid |
| map_mode | input | 2 | Slot layout select |
| mirror | input | 1 | Reverse slot order on data lanes |
| lane_data | output | 4 | Data lane bits, one per lane |
| lane_clk | output | 1 | Clock lane bit |

## Verification
Two things can happen on the same `fast_en` pulse: the slot-0 emission that starts a pixel, and the sampling of a new mode, mirror setting and pixel. The emitted bit must come from the newly sampled values, while the six slots that follow must ignore any later input changes. The bench provokes this by changing the pixel, the mode and the mirror setting at random on every cycle, including the cycle just before slot 0 and directed mid-pixel changes. An independent model samples its own copy of the inputs only at slot 0, and every emitted bit is judged against that model.

// File: rtl/lvds_ser_pkg.sv
// Shared constants and types for the seven-slot lane serializer.
// Assumes 8-bit color components and a four-lane physical link.
package lvds_ser_pkg;
    localparam int SLOTS   = 7;
    localparam int LANES   = 4;
    localparam int COLOR_W = 8;
    localparam int SLOT_W  = $clog2(SLOTS);

    typedef enum logic [1:0] {
        MAP_18     = 2'b00,
        MAP_24_MSB = 2'b01,
        MAP_24_LSB = 2'b10,
        MAP_18_ALT = 2'b11
    } map_mode_e;

    // Clock lane value per slot, bit index equals slot number
    localparam logic [SLOTS-1:0] CLK_WAVE = 7'b1100011;

    // Packs seven slot values so that result[s] is slot s
    function automatic logic [SLOTS-1:0] pack_slots(
        input logic s0, input logic s1, input logic s2, input logic s3,
        input logic s4, input logic s5, input logic s6);
        return {s6, s5, s4, s3, s2, s1, s0};
    endfunction
endpackage

// File: rtl/lvds_slot_counter.sv
// Slot counter: counts slots 0..NSLOT-1 on each advance pulse and wraps.
// Assumes adv is a single-cycle enable synchronous to clk.
module lvds_slot_counter #(
    parameter int NSLOT = 7,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [SW-1:0] slot,
    output logic          at_first
);
    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    // Advance the slot index on each enable, wrap after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (adv)
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end

    assign at_first = (slot == '0);

    p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);
    p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adv && slot == LAST |=> slot == '0);
    p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adv && slot != LAST |=> slot == $past(slot) + 1'b1);
endmodule

// File: rtl/lvds_lane_mapper.sv
// Lane mapper: places color and control bits into per-lane slot words
// for the selected layout. Purely combinational.
// Assumes out[l][s] is the bit for lane l in slot s (normal order).
module lvds_lane_mapper
    import lvds_ser_pkg::*;
(
    input  logic [COLOR_W-1:0]            r,
    input  logic [COLOR_W-1:0]            g,
    input  logic [COLOR_W-1:0]            b,
    input  logic                          hs,
    input  logic                          vs,
    input  logic                          dv,
    input  logic [1:0]                    mode,
    output logic [LANES-1:0][SLOTS-1:0]   out
);
    logic [5:0] r6, g6, b6;
    map_mode_e  m;

    assign m = map_mode_e'(mode);

    // Select which six bits of each color feed lanes 0 to 2
    always_comb begin
        if (m == MAP_24_MSB) begin
            r6 = r[7:2]; g6 = g[7:2]; b6 = b[7:2];
        end else begin
            r6 = r[5:0]; g6 = g[5:0]; b6 = b[5:0];
        end
    end

    // Build the four lane words for the active layout
    always_comb begin
        out[0] = pack_slots(g6[0], r6[5], r6[4], r6[3], r6[2], r6[1], r6[0]);
        out[1] = pack_slots(b6[1], b6[0], g6[5], g6[4], g6[3], g6[2], g6[1]);
        out[2] = pack_slots(dv, vs, hs, b6[5], b6[4], b6[3], b6[2]);
        case (m)
            MAP_24_MSB: out[3] = pack_slots(1'b0, b[1], b[0], g[1], g[0], r[1], r[0]);
            MAP_24_LSB: out[3] = pack_slots(1'b0, b[7], b[6], g[7], g[6], r[7], r[6]);
            default:    out[3] = '0;
        endcase
    end
endmodule

// File: rtl/lvds_slot_picker.sv
// Slot picker: returns the bit of a slot word for the current slot,
// optionally in reversed slot order. Purely combinational.
module lvds_slot_picker #(
    parameter int NSLOT = 7,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] word,
    input  logic [SW-1:0]    slot,
    input  logic             rev,
    output logic             bit_o
);
    logic [SW-1:0] idx;

    // Map the slot number to a word index, reversed when requested
    always_comb begin
        idx   = rev ? (SW'(NSLOT - 1) - slot) : slot;
        bit_o = word[idx];
    end
endmodule

// File: rtl/lvds_serializer.sv
// Seven-slot pixel lane serializer top level.
// Samples a pixel, mode and mirror setting on the enable that emits
// slot 0 and sends one slot per enable on each lane.
// Assumes fast_en pulses exactly seven times per pixel period.
module lvds_serializer
    import lvds_ser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fast_en,
    input  logic [7:0]         pix_r,
    input  logic [7:0]         pix_g,
    input  logic [7:0]         pix_b,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               de,
    input  logic [1:0]         map_mode,
    input  logic               mirror,
    output logic [3:0]         lane_data,
    output logic               lane_clk
);
    logic [SLOT_W-1:0]              slot;
    logic                           at_first;
    logic [LANES-1:0][SLOTS-1:0]    mapped;
    logic [LANES-1:0][SLOTS-1:0]    frame_q;
    logic [LANES-1:0][SLOTS-1:0]    src;
    logic                           mirror_q;
    logic [1:0]                     mode_q;
    logic                           rev_now;
    logic [LANES-1:0]               pick;
    logic                           clk_bit;

    lvds_slot_counter #(.NSLOT(SLOTS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (fast_en),
        .slot     (slot),
        .at_first (at_first)
    );

    lvds_lane_mapper u_map (
        .r    (pix_r),
        .g    (pix_g),
        .b    (pix_b),
        .hs   (hsync),
        .vs   (vsync),
        .dv   (de),
        .mode (map_mode),
        .out  (mapped)
    );

    // Slot 0 is sent straight from the inputs; later slots from the held frame
    always_comb begin
        src     = at_first ? mapped : frame_q;
        rev_now = at_first ? mirror : mirror_q;
    end

    genvar ln;
    generate
        for (ln = 0; ln < LANES; ln++) begin : g_lane
            lvds_slot_picker #(.NSLOT(SLOTS)) u_pick (
                .word  (src[ln]),
                .slot  (slot),
                .rev   (rev_now),
                .bit_o (pick[ln])
            );
        end
    endgenerate

    lvds_slot_picker #(.NSLOT(SLOTS)) u_clk_pick (
        .word  (CLK_WAVE),
        .slot  (slot),
        .rev   (1'b0),
        .bit_o (clk_bit)
    );

    // Hold the pixel frame and its settings for the rest of the pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q  <= '0;
            mirror_q <= 1'b0;
            mode_q   <= MAP_18;
        end else if (fast_en && at_first) begin
            frame_q  <= mapped;
            mirror_q <= mirror;
            mode_q   <= map_mode;
        end
    end

    // Register one slot per enable onto the lane outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_data <= '0;
            lane_clk  <= 1'b0;
        end else if (fast_en) begin
            lane_data <= pick;
            lane_clk  <= clk_bit;
        end
    end

    p_rst_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> lane_data == '0 && !lane_clk);
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_en |=> $stable(lane_data) && $stable(lane_clk));
    p_lane3_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MAP_18 || mode_q == MAP_18_ALT) |-> !lane_data[3]);
    p_clk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fast_en && slot >= SLOT_W'(2) && slot <= SLOT_W'(4) |=> !lane_clk);
    p_clk_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fast_en && at_first |=> lane_clk);
endmodule

// File: tb/lvds_serializer_bench.sv
`timescale 1ns/1ps
module lvds_serializer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_en = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       hsync = 1'b0, vsync = 1'b0, de = 1'b0;
    logic [1:0] map_mode = 2'b00;
    logic       mirror = 1'b0;
    logic [3:0] lane_data;
    logic       lane_clk;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // Model state
    int         m_slot = 0;
    logic [3:0][6:0] m_word = '0;
    logic       m_mir = 0;
    logic [1:0] m_mode = 0;
    logic [3:0] e_data = '0;
    logic       e_clk = 0;
    string      force_tag = "";

    always #2.5 clk = ~clk;

    lvds_serializer u_lvds_serializer (
        .clk(clk), .rst_n(rst_n), .fast_en(fast_en),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .hsync(hsync), .vsync(vsync), .de(de),
        .map_mode(map_mode), .mirror(mirror),
        .lane_data(lane_data), .lane_clk(lane_clk)
    );

    function automatic logic [3:0][6:0] exp_map(input logic [1:0] md,
        input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
        input logic hs, input logic vs, input logic dv);
        logic [3:0][6:0] e;
        logic [5:0] rr, gg, bb;
        e = '0;
        if (md == 2'b01) begin rr = r[7:2]; gg = g[7:2]; bb = b[7:2]; end
        else begin rr = r[5:0]; gg = g[5:0]; bb = b[5:0]; end
        e[0][0] = gg[0];
        for (int i = 1; i < 7; i++) e[0][i] = rr[6-i];
        e[1][0] = bb[1]; e[1][1] = bb[0];
        for (int i = 2; i < 7; i++) e[1][i] = gg[7-i];
        e[2][0] = dv; e[2][1] = vs; e[2][2] = hs;
        for (int i = 3; i < 7; i++) e[2][i] = bb[8-i];
        if (md == 2'b01) begin
            e[3][1] = b[1]; e[3][2] = b[0]; e[3][3] = g[1];
            e[3][4] = g[0]; e[3][5] = r[1]; e[3][6] = r[0];
        end else if (md == 2'b10) begin
            e[3][1] = b[7]; e[3][2] = b[6]; e[3][3] = g[7];
            e[3][4] = g[6]; e[3][5] = r[7]; e[3][6] = r[6];
        end
        return e;
    endfunction

    function automatic logic clk_wave(input int k);
        return (k <= 1 || k >= 5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // One clock cycle with the given enable; model update and output check
    task automatic tick(input bit en);
        string tag;
        int k;
        bit first;
        fast_en = en;
        @(posedge clk);
        k = m_slot;
        first = 0;
        if (en) begin
            if (k == 0) begin
                m_word = exp_map(map_mode, pix_r, pix_g, pix_b, hsync, vsync, de);
                m_mir  = mirror;
                m_mode = map_mode;
                first  = 1;
            end
            for (int l = 0; l < 4; l++) e_data[l] = m_word[l][m_mir ? 6-k : k];
            e_clk  = clk_wave(k);
            m_slot = (k == 6) ? 0 : k + 1;
        end
        @(negedge clk);
        if (force_tag != "") tag = force_tag;
        else if (!en) tag = "R13";
        else if (m_mir) tag = "R8";
        else case (m_mode)
            2'b00: tag = "R3";
            2'b01: tag = "R5";
            2'b10: tag = "R6";
            default: tag = "R4";
        endcase
        chk(tag, {28'd0, lane_data}, {28'd0, e_data});
        chk(m_mir ? "R9" : "R2", {31'd0, lane_clk}, {31'd0, e_clk});
        if (m_mode == 2'b00 || m_mode == 2'b11)
            chk("R11", {31'd0, lane_data[3]}, 32'd0);
        if (en && first && !m_mir && m_mode != 2'b00 && m_mode != 2'b11)
            chk("R7", {31'd0, lane_data[3]}, 32'd0);
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            fast_en = 1'($urandom_range(0, 1));
            @(posedge clk);
            @(negedge clk);
            chk("R12", {27'd0, lane_data, lane_clk}, 32'd0);
        end
        rst_n = 1'b1;
        m_slot = 0; m_word = '0; m_mir = 0; m_mode = 0;
        e_data = '0; e_clk = 0;
    endtask

    task automatic set_pix(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                           input logic hs, input logic vs, input logic dv);
        pix_r = r; pix_g = g; pix_b = b; hsync = hs; vsync = vs; de = dv;
    endtask

    task automatic randomize_inputs();
        set_pix(8'($urandom), 8'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));
        map_mode = 2'($urandom);
        mirror   = 1'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        @(negedge clk);
        do_reset(3);

        // R1: single bit at r0 in the 18-bit layout shows up in slot 6 of lane 0
        force_tag = "R1";
        map_mode = 2'b00; mirror = 1'b0;
        set_pix(8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 14; i++) tick(1);

        // R7: each control bit alone
        force_tag = "R7";
        set_pix(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) tick(1);
        set_pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 7; i++) tick(1);
        map_mode = 2'b10;
        set_pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 7; i++) tick(1);

        // R10: change everything mid-pixel, old pixel must finish unchanged
        force_tag = "R10";
        map_mode = 2'b01; mirror = 1'b0;
        set_pix(8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 1'b1);
        tick(1);
        map_mode = 2'b10; mirror = 1'b1;
        set_pix(8'h5A, 8'hC3, 8'h0F, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) tick(1);
        for (int i = 0; i < 7; i++) tick(1);
        force_tag = "";

        // Mode sweep including the alias encoding, both mirror settings
        for (int md = 0; md < 4; md++) begin
            for (int mr = 0; mr < 2; mr++) begin
                map_mode = 2'(md); mirror = 1'(mr);
                set_pix(8'($urandom), 8'($urandom), 8'($urandom),
                        1'($urandom), 1'($urandom), 1'($urandom));
                for (int i = 0; i < 7; i++) tick(1);
            end
        end

        // Random stream with gaps in the enable and inputs changing every cycle
        for (int i = 0; i < 3000; i++) begin
            randomize_inputs();
            tick($urandom_range(0, 99) < 80);
        end

        // Reset in the middle of a pixel restarts at slot 0
        for (int i = 0; i < 3; i++) tick(1);
        do_reset(2);
        for (int i = 0; i < 200; i++) begin
            randomize_inputs();
            tick($urandom_range(0, 99) < 90);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule